// File: doc/BRIEF.md
# Inbound Memory Window Decoder

This block decides whether an address arriving from an external bus falls into one of a small set of inbound windows, and if so, where that address lands in host memory. Each window is programmed by a single 32-bit configuration word that packs a bus-side base address with a 4-bit logarithmic size code. Sizes run from 1 MB up to 2 GB. The host-side base of every window is address zero, so the translated address is simply the offset of the bus address inside the window.

All windows are compared in parallel. The lowest-numbered window that matches is reported, along with the translated address. When no window matches, a miss flag is raised. Configuration words are loaded on the clock. Decoding is purely combinational from the current bus address and the stored words, so a bus agent can resolve an address in the same cycle it presents it.

Top module: `inbound_window_decoder`

## Requirements
- R1: After reset every window word is zero, so each window has base 0 and size code 0 (1 MB). Addresses 0x0000_0000 to 0x000F_FFFF therefore hit window 0, and address 0x0010_0000 misses.
- R2: On a clock edge with `cfg_we` high and `cfg_sel` equal to 0, 1 or 2, the word on `cfg_wdata` is stored for that window. The base comes from bits 31:20 and the size code from bits 19:16. Bits 15:0 have no effect on decoding.
- R3: A write with `cfg_sel` equal to 3 changes no window.
- R4: Size code c (0 to 11) gives a window of 2^(20+c) bytes. An address hits when its bits 31:(20+c) equal the same bits of the base, so base bits below the window size are ignored.
- R5: A window whose size code is 12 to 15 never hits.
- R6: When several windows hit, `win_idx` reports the lowest-numbered one. It is encoded as 0, 1 or 2.
- R7: When no window hits, `win_miss` is 1, `win_idx` is 0 and `host_addr` is 0. On a hit, `win_miss` is 0.
- R8: On a hit, `host_addr` equals the bus address with every bit at or above position 20+c cleared, where c is the size code of the winning window.
- R9: The three outputs follow `bus_addr` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Window number written (3 is ignored) |
| cfg_wdata | input | 32 | Configuration word: base in 31:20, size code in 19:16 |
| bus_addr | input | 32 | Incoming bus-side address |
| win_miss | output | 1 | No window matches |
| win_idx | output | 2 | Number of the winning window |
| host_addr | output | 32 | Translated host address |

## Verification
The smallest window (code 0) and the largest (code 11) are each probed just below, at and just above their edges. This shows whether the size decode and the offset mask agree in width. Deliberately overlapping windows, with the higher-numbered one either larger or smaller, show whether priority goes to the lowest index. Illegal codes, a misaligned base and writes to the unused select value tell a true miss apart from a stale or wrongly aligned match. Random configuration words and addresses, half of them drawn near a programmed base, then sweep the remaining combinations against a bench model.

// File: rtl/iwd_pkg.sv
package iwd_pkg;
   // Default geometry of the window configuration word
   localparam int unsigned IWD_ADDR_W   = 32;
   localparam int unsigned IWD_NUM_WIN  = 3;
   localparam int unsigned IWD_SEL_W    = 2;
   localparam int unsigned IWD_BASE_LSB = 20;
   localparam int unsigned IWD_CODE_LSB = 16;
   localparam int unsigned IWD_CODE_W   = 4;
   localparam int unsigned IWD_MAX_CODE = 11;
endpackage

// File: rtl/iwd_regs.sv
module iwd_regs #(
   parameter int unsigned ADDR_W   = iwd_pkg::IWD_ADDR_W,
   parameter int unsigned NUM_WIN  = iwd_pkg::IWD_NUM_WIN,
   parameter int unsigned SEL_W    = iwd_pkg::IWD_SEL_W,
   parameter int unsigned CODE_LSB = iwd_pkg::IWD_CODE_LSB,
   localparam int unsigned KEEP_W  = ADDR_W - CODE_LSB
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              we_i,
   input  logic [SEL_W-1:0]                  sel_i,
   input  logic [ADDR_W-1:0]                 wdata_i,
   output logic [NUM_WIN-1:0][KEEP_W-1:0]    cfg_q
);

   // Bits below the size field carry nothing the decoder uses
   logic unused_lo;
   assign unused_lo = ^wdata_i[CODE_LSB-1:0];

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q[w] <= '0;
         end else if (we_i && (32'(sel_i) == w)) begin
            cfg_q[w] <= wdata_i[ADDR_W-1:CODE_LSB];
         end
      end

      assert_write_R2 : assert property (@(posedge clk) disable iff (!rst_n)
         (we_i && (32'(sel_i) == w)) |=> (cfg_q[w] == $past(wdata_i[ADDR_W-1:CODE_LSB])));
   end

   assert_bad_sel_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!we_i || (32'(sel_i) >= NUM_WIN)) |=> $stable(cfg_q));

endmodule

// File: rtl/iwd_match.sv
module iwd_match #(
   parameter int unsigned ADDR_W   = iwd_pkg::IWD_ADDR_W,
   parameter int unsigned BASE_LSB = iwd_pkg::IWD_BASE_LSB,
   parameter int unsigned CODE_W   = iwd_pkg::IWD_CODE_W,
   parameter int unsigned MAX_CODE = iwd_pkg::IWD_MAX_CODE
) (
   input  logic [ADDR_W-BASE_LSB-1:0] base_i,
   input  logic [CODE_W-1:0]          code_i,
   input  logic [ADDR_W-1:0]          addr_i,
   output logic                       hit_o,
   output logic [ADDR_W-1:0]          offs_o
);

   logic [ADDR_W-1:0] span_mask;   // ones over the in-window offset bits
   logic [ADDR_W-1:0] base_full;
   logic              code_ok;

   always_comb begin
      for (int i = 0; i < int'(ADDR_W); i++) begin
         span_mask[i] = (i < (int'(BASE_LSB) + int'(code_i)));
      end
   end

   assign code_ok   = (int'(code_i) <= int'(MAX_CODE));
   assign base_full = {base_i, {BASE_LSB{1'b0}}};
   assign hit_o     = code_ok && (((addr_i ^ base_full) & ~span_mask) == '0);
   assign offs_o    = addr_i & span_mask;

endmodule

// File: rtl/iwd_prio.sv
module iwd_prio #(
   parameter int unsigned ADDR_W  = iwd_pkg::IWD_ADDR_W,
   parameter int unsigned NUM_WIN = iwd_pkg::IWD_NUM_WIN,
   parameter int unsigned SEL_W   = iwd_pkg::IWD_SEL_W
) (
   input  logic [NUM_WIN-1:0]             hit_vec_i,
   input  logic [NUM_WIN-1:0][ADDR_W-1:0] offs_vec_i,
   output logic                           miss_o,
   output logic [SEL_W-1:0]               idx_o,
   output logic [ADDR_W-1:0]              xlat_o
);

   assign miss_o = ~|hit_vec_i;

   if (NUM_WIN == 1) begin : g_single
      assign idx_o  = '0;
      assign xlat_o = hit_vec_i[0] ? offs_vec_i[0] : '0;
   end else begin : g_chain
      // Walk from the top so the lowest matching index is applied last
      always_comb begin
         idx_o  = '0;
         xlat_o = '0;
         for (int w = int'(NUM_WIN) - 1; w >= 0; w--) begin
            if (hit_vec_i[w]) begin
               idx_o  = SEL_W'(w);
               xlat_o = offs_vec_i[w];
            end
         end
      end
   end

endmodule

// File: rtl/inbound_window_decoder.sv
module inbound_window_decoder #(
   parameter int unsigned ADDR_W   = iwd_pkg::IWD_ADDR_W,
   parameter int unsigned NUM_WIN  = iwd_pkg::IWD_NUM_WIN,
   parameter int unsigned SEL_W    = iwd_pkg::IWD_SEL_W,
   parameter int unsigned BASE_LSB = iwd_pkg::IWD_BASE_LSB,
   parameter int unsigned CODE_LSB = iwd_pkg::IWD_CODE_LSB,
   parameter int unsigned CODE_W   = iwd_pkg::IWD_CODE_W,
   parameter int unsigned MAX_CODE = iwd_pkg::IWD_MAX_CODE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              win_miss,
   output logic [SEL_W-1:0]  win_idx,
   output logic [ADDR_W-1:0] host_addr
);

   localparam int unsigned KEEP_W  = ADDR_W - CODE_LSB;
   localparam int unsigned BASE_OF = BASE_LSB - CODE_LSB;

   // Elaboration-time parameter checks
   if (NUM_WIN < 1 || (2 ** SEL_W) < NUM_WIN) begin : g_bad_count
      $error("window count does not fit the select width");
   end
   if (CODE_LSB + CODE_W != BASE_LSB) begin : g_bad_fields
      $error("size field must sit directly below the base field");
   end
   if (BASE_LSB + MAX_CODE >= ADDR_W) begin : g_bad_span
      $error("largest window must leave at least one compared bit");
   end
   if (MAX_CODE >= (2 ** CODE_W)) begin : g_bad_code
      $error("largest size code does not fit the size field");
   end

   logic [NUM_WIN-1:0][KEEP_W-1:0] cfg_q;
   logic [NUM_WIN-1:0]             hit_vec;
   logic [NUM_WIN-1:0][ADDR_W-1:0] offs_vec;

   iwd_regs #(
      .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .SEL_W(SEL_W), .CODE_LSB(CODE_LSB)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .sel_i(cfg_sel),
      .wdata_i(cfg_wdata), .cfg_q(cfg_q)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      iwd_match #(
         .ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE)
      ) u_match (
         .base_i(cfg_q[w][KEEP_W-1:BASE_OF]),
         .code_i(cfg_q[w][CODE_W-1:0]),
         .addr_i(bus_addr),
         .hit_o(hit_vec[w]),
         .offs_o(offs_vec[w])
      );

      assert_illegal_code_R5 : assert property (@(posedge clk) disable iff (!rst_n)
         (int'(cfg_q[w][CODE_W-1:0]) > int'(MAX_CODE)) |-> !hit_vec[w]);
   end

   iwd_prio #(
      .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .SEL_W(SEL_W)
   ) u_prio (
      .hit_vec_i(hit_vec), .offs_vec_i(offs_vec),
      .miss_o(win_miss), .idx_o(win_idx), .xlat_o(host_addr)
   );

   // Windows numbered below the reported one
   logic [NUM_WIN-1:0] below_sel;
   logic [CODE_W-1:0]  win_code;
   always_comb begin
      below_sel = (NUM_WIN'(1) << win_idx) - NUM_WIN'(1);
      win_code  = cfg_q[win_idx][CODE_W-1:0];
   end

   assert_lowest_wins_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !win_miss |-> (hit_vec[win_idx] && ((hit_vec & below_sel) == '0)));

   assert_miss_zero_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      win_miss |-> (hit_vec == '0 && win_idx == '0 && host_addr == '0));

   assert_offset_span_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !win_miss |-> ((host_addr[BASE_LSB-1:0] == bus_addr[BASE_LSB-1:0]) &&
                     ((host_addr >> (int'(BASE_LSB) + int'(win_code))) == '0)));

endmodule

// File: tb/inbound_window_decoder_tb.sv
module inbound_window_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] bus_addr = '0;
   logic        win_miss;
   logic [1:0]  win_idx;
   logic [31:0] host_addr;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;
   logic [15:0] mdl [3];   // [15:4] base, [3:0] size code

   always #4 clk = ~clk;   // 125 MHz

   inbound_window_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .bus_addr(bus_addr),
      .win_miss(win_miss), .win_idx(win_idx), .host_addr(host_addr)
   );

   function automatic void model(input logic [31:0] a, output logic m,
                                 output logic [1:0] ix, output logic [31:0] x);
      m = 1'b1; ix = 2'd0; x = 32'd0;
      for (int w = 2; w >= 0; w--) begin
         int c;
         logic [63:0] sz;
         c = int'(mdl[w][3:0]);
         if (c <= 11) begin
            sz = 64'd1 << (20 + c);
            if ((64'(a) / sz) == (64'({mdl[w][15:4], 20'h0}) / sz)) begin
               m = 1'b0; ix = 2'(w); x = 32'(64'(a) % sz);
            end
         end
      end
   endfunction

   task automatic cmp(input logic em, input logic [1:0] ei, input logic [31:0] ex,
                      input string tag);
      n_chk++;
      if (win_miss !== em || win_idx !== ei || host_addr !== ex) begin
         n_err++;
         $display("FAIL %s addr=%h got miss=%b idx=%0d xlat=%h exp miss=%b idx=%0d xlat=%h",
                  tag, bus_addr, win_miss, win_idx, host_addr, em, ei, ex);
      end
   endtask

   // Directed check with explicit expectation, also cross-checked against the model
   task automatic chk_exp(input logic [31:0] a, input logic em, input logic [1:0] ei,
                          input logic [31:0] ex, input string tag);
      logic mm; logic [1:0] mi; logic [31:0] mx;
      @(negedge clk);
      bus_addr = a;
      #1;
      cmp(em, ei, ex, tag);
      model(a, mm, mi, mx);
      cmp(mm, mi, mx, {tag, " model"});
   endtask

   task automatic chk_mdl(input logic [31:0] a, input string tag);
      logic mm; logic [1:0] mi; logic [31:0] mx;
      @(negedge clk);
      bus_addr = a;
      #1;
      model(a, mm, mi, mx);
      cmp(mm, mi, mx, tag);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel != 2'd3) mdl[sel] = d[31:16];
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      for (int w = 0; w < 3; w++) mdl[w] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset contents
      chk_exp(32'h000F_FFFF, 1'b0, 2'd0, 32'h000F_FFFF, "R1 reset top of 1MB");
      chk_exp(32'h0010_0000, 1'b1, 2'd0, 32'h0, "R1 reset above 1MB");

      // R2/R4/R8: 4MB window at 0x1000_0000, low word bits set but ignored
      wr(2'd0, 32'h1002_FFFF);
      wr(2'd1, 32'h000C_0000);   // illegal code parks window 1
      wr(2'd2, 32'h000F_0000);   // illegal code parks window 2
      chk_exp(32'h0FFF_FFFF, 1'b1, 2'd0, 32'h0, "R4 below base");
      chk_exp(32'h1000_0000, 1'b0, 2'd0, 32'h0, "R2 base hit");
      chk_exp(32'h103F_FFFF, 1'b0, 2'd0, 32'h003F_FFFF, "R8 top of 4MB");
      chk_exp(32'h1040_0000, 1'b1, 2'd0, 32'h0, "R7 above 4MB");

      // R5: illegal codes never hit, even at their base
      chk_exp(32'h0000_0000, 1'b1, 2'd0, 32'h0, "R5 code 12 and 15");

      // R4/R8: 2GB window (code 11)
      wr(2'd1, 32'h800B_0000);
      chk_exp(32'h7FFF_FFFF, 1'b1, 2'd0, 32'h0, "R4 below 2GB");
      chk_exp(32'h8000_0000, 1'b0, 2'd1, 32'h0, "R4 2GB base");
      chk_exp(32'hFFFF_FFFF, 1'b0, 2'd1, 32'h7FFF_FFFF, "R8 2GB top");

      // R4: misaligned base 0x201 with 2MB is aligned down to 0x2000_0000
      wr(2'd2, 32'h2011_0000);
      chk_exp(32'h2000_0000, 1'b0, 2'd2, 32'h0, "R4 misaligned base");
      chk_exp(32'h201F_FFFF, 1'b0, 2'd2, 32'h001F_FFFF, "R4 misaligned top");
      chk_exp(32'h2020_0000, 1'b1, 2'd0, 32'h0, "R4 misaligned above");

      // R3: write to select 3 must not create a window at 0x4000_0000
      wr(2'd3, 32'h400B_0000);
      chk_exp(32'h4000_0000, 1'b1, 2'd0, 32'h0, "R3 sel3 ignored");
      chk_exp(32'h2000_0004, 1'b0, 2'd2, 32'h4, "R3 window 2 kept");

      // R6: overlap, window 2 larger than window 0
      wr(2'd2, 32'h1005_0000);   // 32MB at 0x1000_0000
      chk_exp(32'h1000_0010, 1'b0, 2'd0, 32'h10, "R6 w0 over w2");
      chk_exp(32'h1050_0000, 1'b0, 2'd2, 32'h0050_0000, "R6 only w2");
      wr(2'd1, 32'h000B_0000);   // 2GB at 0 covers both
      chk_exp(32'h1000_0000, 1'b0, 2'd0, 32'h0, "R6 w0 over w1 w2");
      chk_exp(32'h1100_0000, 1'b0, 2'd1, 32'h1100_0000, "R6 w1 over w2");
      chk_exp(32'h9000_0000, 1'b1, 2'd0, 32'h0, "R7 outside all");

      // R9: two addresses within one low clock phase
      @(negedge clk);
      bus_addr = 32'h1000_0020;
      #1; cmp(1'b0, 2'd0, 32'h20, "R9 first address");
      bus_addr = 32'h1060_0000;
      #1; cmp(1'b0, 2'd1, 32'h1060_0000, "R9 second address");

      // Random configuration and addresses
      for (int it = 0; it < 600; it++) begin
         if (it % 5 == 0) begin
            logic [31:0] d;
            d = $urandom;
            if ($urandom % 4 != 0) d[19:16] = 4'($urandom % 12);
            wr(2'($urandom % 4), d);
         end
         begin
            logic [31:0] a;
            a = $urandom;
            if ($urandom % 2 == 0) a[31:20] = mdl[$urandom % 3][15:4] ^ 12'($urandom % 4);
            chk_mdl(a, "R4 R6 R8 random");
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule